// File: doc/BRIEF.md
# Interrupt Priority and In-Service Tracker

This block keeps the interrupt state of one processor core across 256 vectors. It stores one request bit and one in-service bit per vector, a task-priority byte set by software, and a stack of the vectors that are currently in service, nested one inside another. From the task priority and the vector on top of the stack it derives the processor priority. It offers the highest requested vector to the core only when that vector's priority class is above the processor priority.

Each 8-bit value has a priority class, which is its upper nibble. A source raises a request with a strobe and a vector number. The core reads the offered vector, and when it takes that vector it pulses the accept strobe. When its handler finishes, it pulses end-of-interrupt. Software writes the task priority and reads back both the task priority and the processor priority.

Top module: `irq_prio_tracker`

## Requirements
- R1: After reset all request and in-service bits are clear, the stack is empty, `tpr_rd`, `ppr_rd` and `ovf_err` are 0, and `pend_valid` is 0.
- R2: A `req_valid` pulse sets the request bit of `req_vec`. Vector v is held in word v/32 at bit v%32. Among requested vectors from 32 to 255, the highest number is the candidate offered on `pend_vec`.
- R3: Vectors 0 to 31 can be requested but are never offered, because the search covers vectors 32 to 255 only.
- R4: `pend_valid` is 1 only when the candidate's class (bits 7:4) is strictly greater than the class of `ppr_rd`. An equal or lower class offers nothing.
- R5: `ppr_rd` equals the task priority when the task-priority class is at least the class of the top-of-stack vector. Otherwise it equals that vector with bits 3:0 cleared. An empty stack counts as vector 0.
- R6: A `tpr_we` pulse stores bits 7:0 of `tpr_wdata`, and the following cycle `tpr_rd` and `ppr_rd` reflect the new value.
- R7: An accept of `accept_vec` clears its request bit, sets its in-service bit and pushes it onto the stack. Processor priority is recomputed in the next cycle.
- R8: An `eoi` pulse clears the highest set in-service bit among vectors 32 to 255 and pops the stack. With nothing in service it has no effect.
- R9: When a request and an accept name the same vector in the same cycle, that vector's request bit ends set.
- R10: The stack holds DEPTH vectors. An accept while DEPTH vectors are in service changes nothing except `ovf_err`, which becomes 1 and stays 1 until reset.
- R11: When `accept` and `eoi` are both asserted in one cycle, only the accept is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Vector being requested |
| accept | input | 1 | Core takes a vector into service |
| accept_vec | input | 8 | Vector being accepted |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data; bits 7:0 are kept |
| tpr_rd | output | 8 | Current task priority |
| ppr_rd | output | 8 | Derived processor priority |
| pend_valid | output | 1 | A vector is offered |
| pend_vec | output | 8 | Offered vector |
| ovf_err | output | 1 | Sticky stack-overflow flag |

## Verification
The bench builds the block with DEPTH set to 4 rather than the default of 16. With that depth, four nested accepts fill the stack, so the overflow path and the sticky flag are exercised after a short sequence. The same run also climbs through several priority classes and covers the equal-class blocking case, the handling of the reserved low vectors and a request colliding with an accept. The nested accept and end-of-interrupt steps at depth 4 use the same stack and priority logic as the default depth.

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [7:0]  req_vec,
  input  logic        accept,
  input  logic [7:0]  accept_vec,
  input  logic        eoi,
  input  logic        tpr_we,
  input  logic [31:0] tpr_wdata,
  output logic [7:0]  tpr_rd,
  output logic [7:0]  ppr_rd,
  output logic        pend_valid,
  output logic [7:0]  pend_vec,
  output logic        ovf_err
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [255:0] irr, isr, irr_n, isr_n;
  logic [7:0]   tpr;
  logic [7:0]   stk [DEPTH+1];
  logic [PW-1:0] top;
  logic         ovf, push, pop, full;
  logic [7:0]   isrv, hi_irr, hi_isr;
  logic         irr_hit, isr_hit;

  assign full   = (top == PW'(DEPTH));
  assign isrv   = stk[top];
  assign ppr_rd = (tpr[7:4] >= isrv[7:4]) ? tpr : {isrv[7:4], 4'h0};
  assign tpr_rd = tpr;
  assign ovf_err = ovf;
  assign pend_vec = hi_irr;
  assign pend_valid = irr_hit && (hi_irr[7:4] > ppr_rd[7:4]);

  always_comb begin
    hi_irr = 8'h00; irr_hit = 1'b0;
    hi_isr = 8'h00; isr_hit = 1'b0;
    for (int i = 32; i < 256; i++) begin
      if (irr[i]) begin hi_irr = 8'(i); irr_hit = 1'b1; end
      if (isr[i]) begin hi_isr = 8'(i); isr_hit = 1'b1; end
    end
  end

  always_comb begin
    irr_n = irr;
    isr_n = isr;
    push  = 1'b0;
    pop   = 1'b0;
    if (accept) begin
      if (!full) begin
        irr_n[accept_vec] = 1'b0;
        isr_n[accept_vec] = 1'b1;
        push = 1'b1;
      end
    end else if (eoi && isr_hit && top != '0) begin
      isr_n[hi_isr] = 1'b0;
      pop = 1'b1;
    end
    if (req_valid) irr_n[req_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      tpr <= '0;
      top <= '0;
      ovf <= 1'b0;
      for (int i = 0; i <= DEPTH; i++) stk[i] <= '0;
    end else begin
      irr <= irr_n;
      isr <= isr_n;
      if (tpr_we) tpr <= tpr_wdata[7:0];
      if (accept && full) ovf <= 1'b1;
      if (push) begin
        top <= top + PW'(1);
        stk[top + PW'(1)] <= accept_vec;
      end else if (pop) begin
        top <= top - PW'(1);
      end
    end
  end
endmodule

module irq_prio_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tpr_we,
  input logic [31:0] tpr_wdata,
  input logic        accept,
  input logic [7:0]  accept_vec,
  input logic        full,
  input logic [7:0]  tpr_rd,
  input logic [7:0]  ppr_rd,
  input logic        pend_valid,
  input logic [7:0]  pend_vec,
  input logic        ovf_err
);
  a_r4_pend_above_ppr: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend_vec[7:4] > ppr_rd[7:4]));

  a_r3_pend_not_low: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend_vec >= 8'd32));

  a_r5_ppr_not_below_tpr: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_rd >= tpr_rd);

  a_r6_tpr_write: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we |=> (tpr_rd == $past(tpr_wdata[7:0])));

  a_r7_accept_raises_ppr: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pend_valid && accept_vec == pend_vec && !full && !tpr_we)
      |=> (ppr_rd == {$past(accept_vec[7:4]), 4'h0}));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  a_r10_ovf_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && full) |=> ovf_err);
endmodule

bind irq_prio_tracker irq_prio_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
  .accept(accept), .accept_vec(accept_vec), .full(full),
  .tpr_rd(tpr_rd), .ppr_rd(ppr_rd), .pend_valid(pend_valid),
  .pend_vec(pend_vec), .ovf_err(ovf_err)
);

// File: tb/irq_prio_tracker_test.sv
module irq_prio_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, accept = 1'b0, eoi = 1'b0, tpr_we = 1'b0;
  logic [7:0] req_vec = '0, accept_vec = '0;
  logic [31:0] tpr_wdata = '0;
  logic [7:0] tpr_rd, ppr_rd, pend_vec;
  logic pend_valid, ovf_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic       pv;
    logic [7:0] pvec;
    logic [7:0] ppr;
    logic [7:0] tpr;
    logic       ovf;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_tracker #(.DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .accept(accept), .accept_vec(accept_vec), .eoi(eoi),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_rd(tpr_rd),
    .ppr_rd(ppr_rd), .pend_valid(pend_valid), .pend_vec(pend_vec),
    .ovf_err(ovf_err)
  );

  task automatic expect_out(input string tag, input logic pv, input logic [7:0] pvec,
                            input logic [7:0] ppr, input logic [7:0] tpr, input logic ovf);
    exp_t e;
    e.tag = tag; e.pv = pv; e.pvec = pvec; e.ppr = ppr; e.tpr = tpr; e.ovf = ovf;
    q.push_back(e);
  endtask

  task automatic cyc(input logic rq, input logic [7:0] rv, input logic ac,
                     input logic [7:0] av, input logic eo, input logic we,
                     input logic [31:0] wd);
    @(negedge clk);
    req_valid = rq; req_vec = rv; accept = ac; accept_vec = av;
    eoi = eo; tpr_we = we; tpr_wdata = wd;
    @(posedge clk);
    #1;
    req_valid = 1'b0; accept = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pend_valid !== e.pv || (e.pv && pend_vec !== e.pvec) ||
          ppr_rd !== e.ppr || tpr_rd !== e.tpr || ovf_err !== e.ovf) begin
        errors++;
        $display("FAIL %s: got pv=%0b vec=%02h ppr=%02h tpr=%02h ovf=%0b, expected pv=%0b vec=%02h ppr=%02h tpr=%02h ovf=%0b",
                 e.tag, pend_valid, pend_vec, ppr_rd, tpr_rd, ovf_err,
                 e.pv, e.pvec, e.ppr, e.tpr, e.ovf);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_out("R1 reset state", 0, 8'h00, 8'h00, 8'h00, 0);

    cyc(1, 8'h05, 0, 0, 0, 0, 0); expect_out("R3 low vector not offered", 0, 0, 8'h00, 8'h00, 0);
    cyc(1, 8'h41, 0, 0, 0, 0, 0); expect_out("R2 request 41", 1, 8'h41, 8'h00, 8'h00, 0);
    cyc(1, 8'h45, 0, 0, 0, 0, 0); expect_out("R2 highest bit in word", 1, 8'h45, 8'h00, 8'h00, 0);
    cyc(1, 8'hA0, 0, 0, 0, 0, 0); expect_out("R2 higher word wins", 1, 8'hA0, 8'h00, 8'h00, 0);

    cyc(0, 0, 0, 0, 0, 1, 32'h1B5); expect_out("R6 low byte kept, R4 blocked", 0, 0, 8'hB5, 8'hB5, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'hA0);  expect_out("R4 equal class blocked", 0, 0, 8'hA0, 8'hA0, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'h9F);  expect_out("R4 higher class offered", 1, 8'hA0, 8'h9F, 8'h9F, 0);

    cyc(0, 0, 1, 8'hA0, 0, 0, 0);   expect_out("R7 accept A0, R5 isr wins", 0, 0, 8'hA0, 8'h9F, 0);
    cyc(1, 8'hB3, 0, 0, 0, 0, 0);   expect_out("R4 nested offer", 1, 8'hB3, 8'hA0, 8'h9F, 0);
    cyc(0, 0, 1, 8'hB3, 0, 0, 0);   expect_out("R7 accept B3", 0, 0, 8'hB0, 8'h9F, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'hC2);  expect_out("R5 tpr class wins", 0, 0, 8'hC2, 8'hC2, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'h00);  expect_out("R5 stack top wins", 0, 0, 8'hB0, 8'h00, 0);

    cyc(0, 0, 0, 0, 1, 0, 0); expect_out("R8 eoi pops B3", 0, 0, 8'hA0, 8'h00, 0);
    cyc(0, 0, 0, 0, 1, 0, 0); expect_out("R8 eoi pops A0", 1, 8'h45, 8'h00, 8'h00, 0);
    cyc(0, 0, 0, 0, 1, 0, 0); expect_out("R8 eoi when empty", 1, 8'h45, 8'h00, 8'h00, 0);

    cyc(0, 0, 1, 8'h45, 0, 0, 0); expect_out("R7 accept 45", 0, 0, 8'h40, 8'h00, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);     expect_out("R7 request of 45 cleared", 1, 8'h41, 8'h00, 8'h00, 0);

    cyc(1, 8'h60, 1, 8'h60, 0, 0, 0); expect_out("R9 same-cycle request and accept", 0, 0, 8'h60, 8'h00, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);         expect_out("R9 request survived", 1, 8'h60, 8'h00, 8'h00, 0);

    cyc(0, 0, 1, 8'h60, 0, 0, 0); expect_out("R10 fill 1", 0, 0, 8'h60, 8'h00, 0);
    cyc(1, 8'h70, 0, 0, 0, 0, 0); expect_out("R10 req 70", 1, 8'h70, 8'h60, 8'h00, 0);
    cyc(0, 0, 1, 8'h70, 0, 0, 0); expect_out("R10 fill 2", 0, 0, 8'h70, 8'h00, 0);
    cyc(1, 8'h80, 0, 0, 0, 0, 0); expect_out("R10 req 80", 1, 8'h80, 8'h70, 8'h00, 0);
    cyc(0, 0, 1, 8'h80, 0, 0, 0); expect_out("R10 fill 3", 0, 0, 8'h80, 8'h00, 0);
    cyc(1, 8'h90, 0, 0, 0, 0, 0); expect_out("R10 req 90", 1, 8'h90, 8'h80, 8'h00, 0);
    cyc(0, 0, 1, 8'h90, 0, 0, 0); expect_out("R10 fill 4 (full)", 0, 0, 8'h90, 8'h00, 0);
    cyc(1, 8'hA5, 0, 0, 0, 0, 0); expect_out("R10 req A5", 1, 8'hA5, 8'h90, 8'h00, 0);
    cyc(0, 0, 1, 8'hA5, 0, 0, 0); expect_out("R10 overflow accept ignored", 1, 8'hA5, 8'h90, 8'h00, 1);
    cyc(0, 0, 0, 0, 1, 0, 0);     expect_out("R10 flag sticky after eoi", 1, 8'hA5, 8'h80, 8'h00, 1);

    cyc(0, 0, 1, 8'hA5, 1, 0, 0); expect_out("R11 accept beats eoi", 0, 0, 8'hA0, 8'h00, 1);

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule